// File: doc/BRIEF.md
# Shared-Adder Arithmetic Logic Unit

This block combines two signed or unsigned operands of a parameterized width under a three-bit function code. It produces a bitwise AND, a bitwise OR, a sum, a difference, or a signed less-than test. A single adder serves every arithmetic function. The top function bit complements the second operand before the datapath sees it. The same bit also acts as the adder's carry-in, so one code bit turns addition into subtraction and turns AND or OR into their complemented-operand variants.

The two low function bits pick one of four candidates: the AND, the OR, the adder sum, or the sum's sign bit placed in bit 0 with every higher bit cleared. Alongside the result, the block reports a zero indication and a signed-overflow indication. All three outputs are registered. A synchronous active-high reset clears them, which leaves the zero indication set.

Top module: `cmp_alu`

## Requirements
- R1: While `rst` is high at a rising edge, that edge sets `res` to 0, `zero` to 1 and `ovf` to 0.
- R2: Outputs change only at a rising edge. They reflect `op_a`, `op_b` and `func` as sampled at that edge, so the latency is one cycle.
- R3: `func` = 3'b000 gives `op_a & op_b`, and `func` = 3'b001 gives `op_a | op_b`.
- R4: `func` = 3'b100 gives `op_a & ~op_b`, and `func` = 3'b101 gives `op_a | ~op_b`.
- R5: `func` = 3'b010 gives `op_a + op_b` modulo 2^WIDTH.
- R6: `func` = 3'b110 gives `op_a - op_b` modulo 2^WIDTH.
- R7: `func` = 3'b111 places in bit 0 the top bit of `op_a - op_b` modulo 2^WIDTH, and clears all higher bits. This is the signed less-than result with overflow ignored.
- R8: `func` = 3'b011 places in bit 0 the top bit of `op_a + op_b` modulo 2^WIDTH, and clears all higher bits.
- R9: `zero` is 1 exactly when every bit of `res` is 0.
- R10: `ovf` is 1 only for `func` = 3'b010 or 3'b110, and only when the signed sum or difference falls outside the signed WIDTH-bit range. For every other code it is 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Rising-edge clock |
| rst | input | 1 | Synchronous active-high reset |
| op_a | input | WIDTH | First operand |
| op_b | input | WIDTH | Second operand, complemented when func[2] is 1 |
| func | input | 3 | Function code; bit 2 inverts `op_b` and feeds carry-in, bits 1:0 pick the result |
| res | output | WIDTH | Registered result |
| zero | output | 1 | Registered all-zero indication of the result |
| ovf | output | 1 | Registered signed overflow of add or subtract |

## Verification
A 32-bit instance walks a fixed vector table that separates the eight codes from one another:
- Complementary bit patterns distinguish AND from OR and the inverted-operand forms from the plain ones.
- A carry wrapping to zero shows that an unsigned carry-out does not raise the overflow flag.
- The largest positive plus one, and the most negative minus one, raise overflow on both sides of the signed range.
- The most negative less-than-one case shows that the less-than test follows the raw sign bit and ignores overflow.

A 4-bit instance is driven with every operand pair under every code. Random 32-bit operands fill the gaps, and directed cases cover the one-cycle latency and a mid-run reset.

// File: rtl/cmp_alu_pkg.sv
package cmp_alu_pkg;
  localparam int FUNC_W = 3;

  typedef enum logic [1:0] {
    SEL_AND  = 2'b00,
    SEL_OR   = 2'b01,
    SEL_SUM  = 2'b10,
    SEL_SIGN = 2'b11
  } sel_e;
endpackage

// File: rtl/cmp_alu_binv.sv
module cmp_alu_binv #(
  parameter int WIDTH = 32
) (
  input  logic [WIDTH-1:0] b_in,
  input  logic             inv,
  output logic [WIDTH-1:0] b_out
);
  // One XOR per bit: inv=1 complements the operand.
  for (genvar i = 0; i < WIDTH; i++) begin : g_bit
    assign b_out[i] = b_in[i] ^ inv;
  end
endmodule

// File: rtl/cmp_alu_adder.sv
module cmp_alu_adder #(
  parameter int WIDTH = 32
) (
  input  logic [WIDTH-1:0] a,
  input  logic [WIDTH-1:0] b,
  input  logic             cin,
  output logic [WIDTH-1:0] sum,
  output logic             sgn_ovf
);
  localparam int MSB = WIDTH - 1;

  always_comb begin
    sum     = a + b + {{(WIDTH-1){1'b0}}, cin};
    // Same-signed inputs with a result of the other sign
    sgn_ovf = (a[MSB] == b[MSB]) && (sum[MSB] != a[MSB]);
  end
endmodule

// File: rtl/cmp_alu_mux.sv
module cmp_alu_mux
  import cmp_alu_pkg::*;
#(
  parameter int WIDTH = 32
) (
  input  sel_e             sel,
  input  logic [WIDTH-1:0] a,
  input  logic [WIDTH-1:0] b,
  input  logic [WIDTH-1:0] sum,
  output logic [WIDTH-1:0] y
);
  localparam int MSB = WIDTH - 1;

  always_comb begin
    unique case (sel)
      SEL_AND:  y = a & b;
      SEL_OR:   y = a | b;
      SEL_SUM:  y = sum;
      SEL_SIGN: y = {{(WIDTH-1){1'b0}}, sum[MSB]};
      default:  y = '0;
    endcase
  end
endmodule

// File: rtl/cmp_alu.sv
module cmp_alu
  import cmp_alu_pkg::*;
#(
  parameter int WIDTH = 32
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [WIDTH-1:0]  op_a,
  input  logic [WIDTH-1:0]  op_b,
  input  logic [FUNC_W-1:0] func,
  output logic [WIDTH-1:0]  res,
  output logic              zero,
  output logic              ovf
);
  logic [WIDTH-1:0] b_eff;
  logic [WIDTH-1:0] sum;
  logic [WIDTH-1:0] y_comb;
  logic             add_ovf;
  logic             vld;
  sel_e             sel;

  assign sel = sel_e'(func[1:0]);

  cmp_alu_binv #(.WIDTH(WIDTH)) u_binv (
    .b_in  (op_b),
    .inv   (func[2]),
    .b_out (b_eff)
  );

  cmp_alu_adder #(.WIDTH(WIDTH)) u_add (
    .a       (op_a),
    .b       (b_eff),
    .cin     (func[2]),
    .sum     (sum),
    .sgn_ovf (add_ovf)
  );

  cmp_alu_mux #(.WIDTH(WIDTH)) u_mux (
    .sel (sel),
    .a   (op_a),
    .b   (b_eff),
    .sum (sum),
    .y   (y_comb)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      res  <= '0;
      zero <= 1'b1;
      ovf  <= 1'b0;
      vld  <= 1'b0;
    end else begin
      res  <= y_comb;
      zero <= ~|y_comb;
      ovf  <= add_ovf && (sel == SEL_SUM);
      vld  <= 1'b1;
    end
  end

  AST_RESET_STATE: assert property (@(posedge clk) disable iff (rst)
    !vld |-> (res == '0 && zero && !ovf)); // R1
  AST_ZERO_MATCH: assert property (@(posedge clk) disable iff (rst)
    zero == (res == '0)); // R9
  AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (rst)
    (vld && $past(func[1:0]) != 2'b10) |-> !ovf); // R10
  AST_SIGN_UPPER: assert property (@(posedge clk) disable iff (rst)
    (vld && $past(func[1:0]) == 2'b11) |-> (res[WIDTH-1:1] == '0)); // R7
  AST_AND_RESULT: assert property (@(posedge clk) disable iff (rst)
    (vld && $past(func) == 3'b000) |-> (res == ($past(op_a) & $past(op_b)))); // R3
  AST_ADD_IDENT: assert property (@(posedge clk) disable iff (rst)
    (vld && $past(func) == 3'b010 && $past(op_b) == '0) |-> (res == $past(op_a))); // R5
endmodule

// File: tb/cmp_alu_tb.sv
module cmp_alu_tb;
  localparam int CLK_PERIOD = 10;
  localparam int W32 = 32;
  localparam int W4  = 4;

  typedef struct packed {
    logic [2:0]  f;
    logic [31:0] a;
    logic [31:0] b;
    logic [31:0] y;
    logic        v;
  } vec_t;

  localparam int NVEC = 12;
  localparam vec_t VECS [NVEC] = '{
    '{3'b000, 32'hF0F0F0F0, 32'hFF00FF00, 32'hF000F000, 1'b0}, // R3
    '{3'b001, 32'hF0F0F0F0, 32'h0F0F0F0F, 32'hFFFFFFFF, 1'b0}, // R3
    '{3'b100, 32'hFFFFFFFF, 32'h0000FFFF, 32'hFFFF0000, 1'b0}, // R4
    '{3'b101, 32'h00000000, 32'hFFFFFFFE, 32'h00000001, 1'b0}, // R4
    '{3'b010, 32'hFFFFFFFF, 32'h00000001, 32'h00000000, 1'b0}, // R5 carry wrap
    '{3'b010, 32'h7FFFFFFF, 32'h00000001, 32'h80000000, 1'b1}, // R5 R10
    '{3'b110, 32'h00000000, 32'h00000001, 32'hFFFFFFFF, 1'b0}, // R6 borrow
    '{3'b110, 32'h80000000, 32'h00000001, 32'h7FFFFFFF, 1'b1}, // R6 R10
    '{3'b111, 32'hFFFFFFFF, 32'h00000001, 32'h00000001, 1'b0}, // R7
    '{3'b111, 32'h00000005, 32'h00000005, 32'h00000000, 1'b0}, // R7 equal
    '{3'b111, 32'h80000000, 32'h00000001, 32'h00000000, 1'b0}, // R7 ovf ignored
    '{3'b011, 32'h40000000, 32'h40000000, 32'h00000001, 1'b0}  // R8
  };

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [31:0] a32 = '0, b32 = '0;
  logic [2:0]  f32 = '0;
  logic [31:0] r32;
  logic        z32, v32;
  logic [3:0]  a4 = '0, b4 = '0;
  logic [2:0]  f4 = '0;
  logic [3:0]  r4;
  logic        z4, v4;

  int n_run  = 0;
  int n_fail = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  cmp_alu #(.WIDTH(W32)) u_dut (
    .clk(clk), .rst(rst), .op_a(a32), .op_b(b32), .func(f32),
    .res(r32), .zero(z32), .ovf(v32)
  );

  cmp_alu #(.WIDTH(W4)) u_dut4 (
    .clk(clk), .rst(rst), .op_a(a4), .op_b(b4), .func(f4),
    .res(r4), .zero(z4), .ovf(v4)
  );

  task automatic check(input string req, input longint act, input longint exp);
    n_run++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  function automatic void model(input int w, input logic [2:0] f,
                                input longint a, input longint b,
                                output longint y, output bit v);
    longint mask = (longint'(1) << w) - 1;
    longint half = longint'(1) << (w - 1);
    longint sa = (a >= half) ? a - (mask + 1) : a;
    longint sb = (b >= half) ? b - (mask + 1) : b;
    longint t;
    v = 1'b0;
    case (f)
      3'd0: y = a & b;
      3'd1: y = a | b;
      3'd2: begin y = (a + b) & mask; t = sa + sb; v = (t >= half) || (t < -half); end
      3'd3: y = ((a + b) & half) != 0 ? 1 : 0;
      3'd4: y = a & ~b & mask;
      3'd5: y = (a | ~b) & mask;
      3'd6: begin y = (a - b) & mask; t = sa - sb; v = (t >= half) || (t < -half); end
      default: y = ((a - b) & half) != 0 ? 1 : 0;
    endcase
  endfunction

  task automatic finish_run();
    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  endtask

  initial begin
    #(CLK_PERIOD * 200000);
    n_run++;
    n_fail++;
    $display("FAIL R2: watchdog expired, actual hung expected done");
    finish_run();
  end

  initial begin
    longint ey;
    bit     ev;
    // R1 reset state
    repeat (3) @(negedge clk);
    check("R1 res", r32, 0);
    check("R1 zero", z32, 1);
    check("R1 ovf", v32, 0);
    check("R1 res4", r4, 0);
    rst = 1'b0;

    // Vector table on the 32-bit instance
    for (int i = 0; i < NVEC; i++) begin
      @(negedge clk);
      f32 = VECS[i].f; a32 = VECS[i].a; b32 = VECS[i].b;
      @(negedge clk);
      check($sformatf("R3-8 vec%0d res", i), r32, VECS[i].y);
      check($sformatf("R10 vec%0d ovf", i), v32, VECS[i].v);
      check($sformatf("R9 vec%0d zero", i), z32, VECS[i].y == 0);
    end

    // R2: inputs changed between edges do not reach the outputs early
    @(negedge clk);
    f32 = 3'b010; a32 = 32'd7; b32 = 32'd8;
    @(negedge clk);
    a32 = 32'd100;
    #1;
    check("R2 hold", r32, 15);
    @(negedge clk);
    check("R2 update", r32, 108);

    // Exhaustive 4-bit sweep
    for (int f = 0; f < 8; f++) begin
      for (int a = 0; a < 16; a++) begin
        for (int b = 0; b < 16; b++) begin
          @(negedge clk);
          f4 = 3'(f); a4 = 4'(a); b4 = 4'(b);
          @(negedge clk);
          model(W4, 3'(f), longint'(a), longint'(b), ey, ev);
          if (r4 != 4'(ey) || v4 != ev || z4 != (ey == 0)) begin
            check($sformatf("R3-R10 w4 f%0d res", f), r4, ey);
            check("R10 w4 ovf", v4, ev);
            check("R9 w4 zero", z4, ey == 0);
          end else n_run++;
        end
      end
    end

    // Random 32-bit operands
    for (int k = 0; k < 400; k++) begin
      @(negedge clk);
      f32 = 3'($urandom_range(7)); a32 = $urandom; b32 = $urandom;
      @(negedge clk);
      model(W32, f32, longint'(a32), longint'(b32), ey, ev);
      check("R5 R6 R7 R8 rand res", r32, ey);
      check("R10 rand ovf", v32, ev);
      check("R9 rand zero", z32, ey == 0);
    end

    // R1 mid-run reset
    @(negedge clk);
    f32 = 3'b001; a32 = 32'hFFFFFFFF; b32 = 0;
    @(negedge clk);
    check("R3 pre-reset", r32, 32'hFFFFFFFF);
    rst = 1'b1;
    @(negedge clk);
    check("R1 midrun res", r32, 0);
    check("R1 midrun zero", z32, 1);
    rst = 1'b0;
    @(negedge clk);
    finish_run();
  end
endmodule